// File: doc/BRIEF.md
# I2C Indexed Register Target

This block is an I2C bus target that exposes a small bank of eight-bit configuration and status registers through an index pointer. A bus master writes the target's address, then one byte that loads the pointer, then any number of data bytes. Each data byte lands in the register the pointer selects, and the pointer then steps forward. Reads return the register at the pointer and step it in the same way. A read normally follows a pointer-setting write, joined to it by a repeated START.

The bank has twelve slots. Slot 0 is a command register that can only be written, and its value appears on its own output. Slots 1 to 8 can be read and written, and their values drive the configuration outputs. Slots 9 to 11 can only be read, and they mirror three status bytes supplied from outside the block. A strap input sets the lowest address bit, so two instances can share one bus. The bus lines are oversampled by the system clock, which must run at ten or more times the SCL rate. This covers both standard (100 kHz) and fast (400 kHz) operation. SDA is driven open-drain through an output-enable that pulls the line low.

Top module: `i2c_idx_regs`

## Requirements
- R1: With `strap_i` low the target acknowledges address byte 0x4C (write) and 0x4D (read), which is 7-bit address 0x26 followed by the R/W bit in bit 0 (1 = read).
- R2: With `strap_i` high the target acknowledges 0x4E (write) and 0x4F (read), which is 7-bit address 0x27, and it no longer answers 0x4C.
- R3: A non-matching address byte gets no acknowledge, and `sda_oe_o` stays low for every later bit until the next START.
- R4: In a write, the first byte after the address loads the 8-bit index pointer. Every later byte writes the register at the pointer, gets an acknowledge, and advances the pointer by one, wrapping from 0xFF to 0x00. Register outputs change only on such a write.
- R5: A read returns the byte at the current pointer, MSB first, and advances the pointer after each byte. The pointer persists across transactions.
- R6: Slot 0 is write-only: a write updates `wo_q_o`, and a read of slot 0 returns 0x00.
- R7: Slots 9 to 11 read back `stat_i` bytes 0, 1 and 2 (byte 0 = bits 7:0). Writes to them are acknowledged and change no output.
- R8: Pointer values 12 and above are acknowledged on write with no effect, and reads there return 0x00.
- R9: A repeated START restarts address decoding at once and releases SDA.
- R10: A master NACK after a read byte ends the transfer, and the target releases SDA until the next START.
- R11: After reset, all register outputs are 0x00 and `sda_oe_o` is low.
- R12: A STOP releases SDA, and the target asserts `sda_oe_o` only while SCL is low at the start of its own bit slot (ACK or read data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 10x the SCL rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 1 | Address select strap, becomes address bit 0 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| wo_q_o | output | 8 | Value of the write-only command slot 0 |
| rw_q_o | output | 64 | Slots 1..8, slot n in bits [8n-1 : 8n-8] |
| stat_i | input | 24 | Status bytes shown in read-only slots 9..11 |

## Verification
The hardest states to reach from the ports are the ones where the pointer has left the populated range. These are writes that cross from the last read/write slot into the read-only slots, reads that run past slot 11, and a pointer that wraps from 0xFF back to the write-only slot. The stimulus reaches them with long multi-byte bursts that start near each boundary, so the auto-increment itself carries the pointer across. A second hard case is the ignore state after a refused address. The bench reaches it by sending a byte equal to a valid address without a START, and the target must stay silent.

// File: rtl/i2c_idx_pkg.sv
package i2c_idx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_RACK,
      ST_IGN
   } i2c_st_e;

   localparam int unsigned ADDR_BITS = 7;

endpackage

// File: rtl/i2c_idx_sync.sv
module i2c_idx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_idx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_o      = scl_pipe[STAGES-1];
   assign sda_o      = sda_pipe[STAGES-1];
   assign scl_rise_o = ~scl_q & scl_o;
   assign scl_fall_o = scl_q & ~scl_o;
   assign start_o    = scl_q & scl_o & sda_q & ~sda_o;
   assign stop_o     = scl_q & scl_o & ~sda_q & sda_o;

endmodule

// File: rtl/i2c_idx_bank.sv
module i2c_idx_bank #(
   parameter int unsigned DW    = 8,
   parameter int unsigned N_RW  = 8,
   parameter int unsigned N_RO  = 3,
   parameter int unsigned IDX_W = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_en_i,
   input  logic [IDX_W-1:0]     wr_idx_i,
   input  logic [DW-1:0]        wr_data_i,
   input  logic [IDX_W-1:0]     rd_idx_i,
   input  logic [N_RO*DW-1:0]   stat_i,
   output logic [DW-1:0]        wo_q_o,
   output logic [N_RW*DW-1:0]   rw_q_o,
   output logic [DW-1:0]        rd_data_o
);

   localparam int unsigned RO_LO = 1 + N_RW;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wo_q_o <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(0)) begin
         wo_q_o <= wr_data_i;
      end
   end

   for (genvar g = 0; g < N_RW; g++) begin : g_rw
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            rw_q_o[g*DW +: DW] <= '0;
         end else if (wr_en_i && wr_idx_i == IDX_W'(g + 1)) begin
            rw_q_o[g*DW +: DW] <= wr_data_i;
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < N_RW; i++) begin
         if (rd_idx_i == IDX_W'(i + 1)) rd_data_o = rw_q_o[i*DW +: DW];
      end
      for (int j = 0; j < N_RO; j++) begin
         if (rd_idx_i == IDX_W'(RO_LO + j)) rd_data_o = stat_i[j*DW +: DW];
      end
   end

endmodule

// File: rtl/i2c_idx_fsm.sv
module i2c_idx_fsm
   import i2c_idx_pkg::*;
#(
   parameter int unsigned DW        = 8,
   parameter int unsigned IDX_W     = 8,
   parameter logic [6:0]  BASE_ADDR = 7'h26
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               sda_s_i,
   input  logic               scl_rise_i,
   input  logic               scl_fall_i,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               strap_i,
   input  logic [DW-1:0]      rd_data_i,
   output logic               sda_oe_o,
   output logic               wr_en_o,
   output logic [IDX_W-1:0]   wr_idx_o,
   output logic [DW-1:0]      wr_data_o,
   output logic [IDX_W-1:0]   idx_o
);

   localparam int unsigned CNT_W = $clog2(DW + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DW);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW - 1);

   i2c_st_e            st;
   logic [DW-1:0]      sh;
   logic [DW-1:0]      tx;
   logic [CNT_W-1:0]   cnt;
   logic [IDX_W-1:0]   idx;
   logic               first;
   logic               rw;
   logic [ADDR_BITS-1:0] my_addr;

   assign my_addr = {BASE_ADDR[ADDR_BITS-1:1], strap_i};
   assign idx_o   = idx;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st        <= ST_IDLE;
         sh        <= '0;
         tx        <= '0;
         cnt       <= '0;
         idx       <= '0;
         first     <= 1'b0;
         rw        <= 1'b0;
         sda_oe_o  <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_idx_o  <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_i) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_i) begin
            st       <= ST_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            case (st)
               ST_ADDR: begin
                  if (scl_rise_i && cnt != CNT_FULL) begin
                     sh  <= {sh[DW-2:0], sda_s_i};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall_i && cnt == CNT_FULL) begin
                     if (sh[DW-1:1] == my_addr) begin
                        sda_oe_o <= 1'b1;
                        rw       <= sh[0];
                        first    <= 1'b1;
                        st       <= ST_AACK;
                     end else begin
                        st <= ST_IGN;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall_i) begin
                     cnt <= '0;
                     if (rw) begin
                        tx       <= rd_data_i;
                        sda_oe_o <= ~rd_data_i[DW-1];
                        st       <= ST_RD;
                     end else begin
                        sda_oe_o <= 1'b0;
                        st       <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise_i && cnt != CNT_FULL) begin
                     sh  <= {sh[DW-2:0], sda_s_i};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall_i && cnt == CNT_FULL) begin
                     sda_oe_o <= 1'b1;
                     st       <= ST_WACK;
                     if (first) begin
                        idx   <= IDX_W'(sh);
                        first <= 1'b0;
                     end else begin
                        wr_en_o   <= 1'b1;
                        wr_idx_o  <= idx;
                        wr_data_o <= sh;
                        idx       <= idx + 1'b1;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall_i) begin
                     sda_oe_o <= 1'b0;
                     cnt      <= '0;
                     st       <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall_i) begin
                     if (cnt == CNT_LAST) begin
                        sda_oe_o <= 1'b0;
                        idx      <= idx + 1'b1;
                        st       <= ST_RACK;
                     end else begin
                        tx       <= {tx[DW-2:0], 1'b0};
                        sda_oe_o <= ~tx[DW-2];
                        cnt      <= cnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise_i && sda_s_i) begin
                     st <= ST_IGN;
                  end else if (scl_fall_i) begin
                     tx       <= rd_data_i;
                     sda_oe_o <= ~rd_data_i[DW-1];
                     cnt      <= '0;
                     st       <= ST_RD;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_idx_regs.sv
module i2c_idx_regs #(
   parameter int unsigned DW          = 8,
   parameter int unsigned N_RW        = 8,
   parameter int unsigned N_RO        = 3,
   parameter int unsigned IDX_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  BASE_ADDR   = 7'h26
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 scl_i,
   input  logic                 sda_i,
   input  logic                 strap_i,
   output logic                 sda_oe_o,
   output logic [DW-1:0]        wo_q_o,
   output logic [N_RW*DW-1:0]   rw_q_o,
   input  logic [N_RO*DW-1:0]   stat_i
);

   localparam int unsigned N_REG = 1 + N_RW + N_RO;

   if (DW != i2c_idx_pkg::ADDR_BITS + 1) begin : g_bad_dw
      $error("i2c_idx_regs: DW must equal address width plus one");
   end
   if ((1 << IDX_W) <= N_REG) begin : g_bad_idx
      $error("i2c_idx_regs: IDX_W too narrow for the register count");
   end
   if (BASE_ADDR[0] != 1'b0) begin : g_bad_base
      $error("i2c_idx_regs: BASE_ADDR bit 0 is taken by the strap");
   end

   logic             scl_s;
   logic             sda_s;
   logic             scl_rise;
   logic             scl_fall;
   logic             start_det;
   logic             stop_det;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [DW-1:0]    wr_data;
   logic [IDX_W-1:0] cur_idx;
   logic [DW-1:0]    rd_data;

   i2c_idx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   i2c_idx_fsm #(.DW(DW), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sda_s_i    (sda_s),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start_det),
      .stop_i     (stop_det),
      .strap_i    (strap_i),
      .rd_data_i  (rd_data),
      .sda_oe_o   (sda_oe_o),
      .wr_en_o    (wr_en),
      .wr_idx_o   (wr_idx),
      .wr_data_o  (wr_data),
      .idx_o      (cur_idx)
   );

   i2c_idx_bank #(.DW(DW), .N_RW(N_RW), .N_RO(N_RO), .IDX_W(IDX_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (wr_data),
      .rd_idx_i  (cur_idx),
      .stat_i    (stat_i),
      .wo_q_o    (wo_q_o),
      .rw_q_o    (rw_q_o),
      .rd_data_o (rd_data)
   );

endmodule

// File: rtl/i2c_idx_chk.sv
module i2c_idx_chk #(
   parameter int unsigned DW    = 8,
   parameter int unsigned N_RW  = 8,
   parameter int unsigned N_RO  = 3,
   parameter int unsigned IDX_W = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               sda_oe_o,
   input logic               scl_s,
   input logic               start_det,
   input logic               stop_det,
   input logic               wr_en,
   input logic [IDX_W-1:0]   wr_idx,
   input logic [DW-1:0]      wo_q_o,
   input logic [N_RW*DW-1:0] rw_q_o
);

   localparam int unsigned RO_HI = N_RW + N_RO;

   a_r11_reset_release: assert property (@(posedge clk_i)
      !rst_ni |=> !sda_oe_o);

   a_r4_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en |=> ($stable(rw_q_o) && $stable(wo_q_o)));

   a_r7_ro_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && wr_idx > IDX_W'(N_RW) && wr_idx <= IDX_W'(RO_HI))
      |=> ($stable(rw_q_o) && $stable(wo_q_o)));

   a_r8_oob_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && wr_idx > IDX_W'(RO_HI)) |=> ($stable(rw_q_o) && $stable(wo_q_o)));

   a_r9_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_det |=> !sda_oe_o);

   a_r12_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_det |=> !sda_oe_o);

   a_r12_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sda_oe_o) |-> !scl_s);

endmodule

bind i2c_idx_regs i2c_idx_chk #(.DW(DW), .N_RW(N_RW), .N_RO(N_RO), .IDX_W(IDX_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .sda_oe_o  (sda_oe_o),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .wo_q_o    (wo_q_o),
   .rw_q_o    (rw_q_o)
);

// File: tb/i2c_idx_regs_tb_top.sv
`timescale 1ns/1ps
module i2c_idx_regs_tb_top;

   localparam int HALF = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        strap = 1'b0;
   logic        sda_oe;
   logic [7:0]  wo_q;
   logic [63:0] rw_q;
   logic [23:0] stat = {8'h3C, 8'h96, 8'h81};
   logic        sda_bus;

   always #2 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_idx_regs dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_bus),
      .strap_i  (strap),
      .sda_oe_o (sda_oe),
      .wo_q_o   (wo_q),
      .rw_q_o   (rw_q),
      .stat_i   (stat)
   );

   int   checks = 0;
   int   errs   = 0;
   logic done   = 1'b0;

   // reference model
   logic [7:0] m_wo = 8'h00;
   logic [7:0] m_rw [8];
   logic [7:0] m_idx = 8'h00;
   logic       m_ok = 1'b0;
   logic       m_rd = 1'b0;
   logic       m_first = 1'b0;
   logic       may_drive = 1'b0;
   logic       cmp_en = 1'b0;

   initial for (int i = 0; i < 8; i++) m_rw[i] = 8'h00;

   function automatic logic [7:0] m_read(input logic [7:0] ix);
      if (ix == 8'd0) return 8'h00;
      if (ix <= 8'd8) return m_rw[ix - 1];
      if (ix <= 8'd11) return stat[(ix - 9) * 8 +: 8];
      return 8'h00;
   endfunction

   function automatic logic [63:0] m_pack();
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_rw[i];
      return v;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!may_drive) chk("R3/R12 SDA driven outside a target slot", {63'd0, sda_oe}, 64'd0);
         if (cmp_en) begin
            chk("R4 command output", {56'd0, wo_q}, {56'd0, m_wo});
            chk("R4 config outputs", rw_q, m_pack());
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, input logic slave, output logic r);
      may_drive = may_drive | slave;
      cmp_en = 1'b0;
      wait_clk(5);
      may_drive = slave;
      cmp_en = 1'b1;
      sda_m = b;
      wait_clk(HALF - 5);
      scl_m = 1'b1;
      wait_clk(HALF / 2);
      r = sda_bus;
      wait_clk(HALF - HALF / 2);
      scl_m = 1'b0;
   endtask

   task automatic do_start();
      wait_clk(5);
      may_drive = 1'b0;
      sda_m = 1'b1;
      wait_clk(HALF);
      scl_m = 1'b1;
      wait_clk(HALF);
      sda_m = 1'b0;
      wait_clk(HALF);
      scl_m = 1'b0;
      m_ok = 1'b0;
   endtask

   task automatic do_stop();
      wait_clk(5);
      may_drive = 1'b0;
      sda_m = 1'b0;
      wait_clk(HALF);
      scl_m = 1'b1;
      wait_clk(HALF);
      sda_m = 1'b1;
      wait_clk(HALF);
      m_ok = 1'b0;
   endtask

   task automatic send_addr(input logic [7:0] b, input string req);
      logic r;
      m_ok    = (b[7:1] == {6'h13, strap});
      m_rd    = b[0];
      m_first = 1'b1;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, r);
      clk_bit(1'b1, m_ok, r);
      chk(req, {63'd0, r}, {63'd0, !m_ok});
   endtask

   task automatic send_data(input logic [7:0] b, input string req);
      logic r;
      logic acc;
      acc = m_ok && !m_rd;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, r);
      if (acc) begin
         if (m_first) begin
            m_idx = b;
            m_first = 1'b0;
         end else begin
            if (m_idx == 8'd0) m_wo = b;
            else if (m_idx <= 8'd8) m_rw[m_idx - 1] = b;
            m_idx = m_idx + 8'd1;
         end
      end
      clk_bit(1'b1, acc, r);
      chk(req, {63'd0, r}, {63'd0, !acc});
   endtask

   task automatic read_data(input logic last, input string req);
      logic [7:0] got;
      logic [7:0] exp;
      logic r;
      exp = m_read(m_idx);
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, 1'b1, r);
         got[i] = r;
      end
      m_idx = m_idx + 8'd1;
      clk_bit(last, 1'b0, r);
      if (last) m_ok = 1'b0;
      chk(req, {56'd0, got}, {56'd0, exp});
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         finish_run();
      end
   end

   initial begin
      wait_clk(6);
      rst_n = 1'b1;
      wait_clk(3);
      // R11 reset state
      chk("R11 sda_oe after reset", {63'd0, sda_oe}, 64'd0);
      chk("R11 command slot after reset", {56'd0, wo_q}, 64'd0);
      chk("R11 config slots after reset", rw_q, 64'd0);
      cmp_en = 1'b1;

      // R1 + R4: burst write from slot 1
      do_start();
      send_addr(8'h4C, "R1 write address ack");
      send_data(8'h01, "R4 index byte ack");
      send_data(8'hA1, "R4 data ack");
      send_data(8'hB2, "R4 data ack");
      send_data(8'hC3, "R4 data ack");
      do_stop();

      // R9 + R5 + R10: set index, repeated start, read burst
      do_start();
      send_addr(8'h4C, "R1 write address ack");
      send_data(8'h02, "R5 index byte ack");
      do_start();
      send_addr(8'h4D, "R9 read address after repeated start");
      read_data(1'b0, "R5 read slot 2");
      read_data(1'b1, "R5 read slot 3 then NACK");
      wait_clk(3 * HALF);
      do_stop();

      // R3: foreign address, then a valid-looking byte without START
      do_start();
      send_addr(8'h4E, "R3 foreign address not acked");
      send_data(8'h4C, "R3 silent until next START");
      do_stop();

      // R4 + R7: write across the end of the read/write slots
      do_start();
      send_addr(8'h4C, "R1 write address ack");
      send_data(8'h07, "R4 index byte ack");
      send_data(8'h77, "R4 write slot 7");
      send_data(8'h88, "R4 write slot 8");
      send_data(8'h99, "R7 write to status slot acked");
      do_stop();

      // R6: write-only slot
      do_start();
      send_addr(8'h4C, "R1 write address ack");
      send_data(8'h00, "R6 index byte ack");
      send_data(8'h5A, "R6 write command slot");
      do_start();
      send_addr(8'h4C, "R9 address after repeated start");
      send_data(8'h00, "R6 index byte ack");
      do_start();
      send_addr(8'h4D, "R1 read address ack");
      read_data(1'b0, "R6 command slot reads 00");
      read_data(1'b1, "R5 read slot 1");
      do_stop();

      // R7 + R8: status slots then past the end
      do_start();
      send_addr(8'h4C, "R1 write address ack");
      send_data(8'h09, "R7 index byte ack");
      do_start();
      send_addr(8'h4D, "R1 read address ack");
      read_data(1'b0, "R7 status byte 0");
      read_data(1'b0, "R7 status byte 1");
      read_data(1'b0, "R7 status byte 2");
      read_data(1'b1, "R8 slot 12 reads 00");
      do_stop();

      // R8: write beyond the bank
      do_start();
      send_addr(8'h4C, "R1 write address ack");
      send_data(8'h0C, "R8 index byte ack");
      send_data(8'h55, "R8 write slot 12 acked");
      send_data(8'h66, "R8 write slot 13 acked");
      do_stop();

      // R2: strap high
      strap = 1'b1;
      wait_clk(5);
      do_start();
      send_addr(8'h4C, "R2 old address refused");
      do_stop();
      do_start();
      send_addr(8'h4E, "R2 write address ack");
      send_data(8'h05, "R2 index byte ack");
      send_data(8'hE5, "R2 write slot 5");
      do_start();
      send_addr(8'h4E, "R2 write address ack");
      send_data(8'h05, "R2 index byte ack");
      do_start();
      send_addr(8'h4F, "R2 read address ack");
      read_data(1'b1, "R2 read slot 5");
      do_stop();

      // R4: pointer wraps from 0xFF into the command slot
      do_start();
      send_addr(8'h4E, "R2 write address ack");
      send_data(8'hFF, "R4 index byte ack");
      send_data(8'h11, "R8 write slot 255 acked");
      send_data(8'h22, "R4 wrapped write to command slot");
      do_stop();

      wait_clk(10);
      chk("R6 final command slot", {56'd0, wo_q}, {56'd0, m_wo});
      chk("R4 final config slots", rw_q, m_pack());
      done = 1'b1;
      finish_run();
   end

endmodule